// File: doc/BRIEF.md
# Streaming Byte-Sample Pulse-Width Modulator

This block turns a stream of 8-bit audio samples into a single pulse-width modulated pin. Software-side logic writes samples through a 16-bit port with two byte-lane strobes. The samples land in a four-entry byte queue. A period counter runs from zero up to a programmable limit. At every wrap it takes the next queued sample and uses it as the duty value for the following period. The pin is high from the start of a period until the counter reaches that duty value.

A word write carries two samples and is split big-endian: the upper byte plays first. A single sample always travels on the low lane. If the queue runs dry, the last duty value keeps playing. Dropping the enable empties the queue and silences the pin.

Top module: `byte_fifo_pwm`

## Requirements
- R1: A write with both lane strobes set enqueues two samples: bits 15:8 first, then bits 7:0.
- R2: A write with only the low-lane strobe set enqueues bits 7:0 as one sample. A write with only the high-lane strobe set enqueues nothing.
- R3: The queue holds 4 samples. `fifoFull` is 1 when 4 are held and `fifoEmpty` is 1 when none are held. Any sample written while the queue is full is discarded.
- R4: If a two-sample write arrives while exactly one slot is free, only bits 15:8 are kept. Free slots are counted from the occupancy before any removal in the same cycle.
- R5: While enabled, the counter steps 0,1,…,`period` and then returns to 0, so one period lasts `period`+1 cycles.
- R6: When the counter wraps and the queue is not empty, the oldest sample becomes the duty value for the next period. `pwmOut` is high in exactly the first `duty` cycles of that period.
- R7: A duty of 0 keeps `pwmOut` low for the whole period. A duty above `period` keeps it high for the whole period, which is 100% duty.
- R8: If the queue is empty at a wrap, the previous duty value is replayed.
- R9: While `enable` is 0, the block empties the queue, holds the counter at 0, clears the duty value and drives `pwmOut` low. It ignores writes during that time. The first period after `enable` rises is therefore fully low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; 0 flushes and silences |
| period | input | 8 | Last counter value of a period |
| wrValid | input | 1 | Sample write strobe |
| wrLaneHi | input | 1 | Byte lane select for bits 15:8 |
| wrLaneLo | input | 1 | Byte lane select for bits 7:0 |
| wrData | input | 16 | Sample write data |
| pwmOut | output | 1 | Modulated output pin |
| fifoEmpty | output | 1 | Queue holds no samples |
| fifoFull | output | 1 | Queue holds 4 samples |

## Verification
Two events can land in the same cycle: a sample write, and the removal of a sample at the period wrap. The bench forces this by loading three samples one per cycle right after enable with a period of 3. It then sends a two-sample write in the exact cycle where the counter sits at its limit. The write must be judged against the occupancy before the removal, so only its upper byte is kept. The played duty sequence 1,2,3,4, followed by a replayed 4, confirms both the removal and the truncated write. A separate run with a long period fills the queue, sends a further write that must be discarded, and reads the played sequence back through the pin.

// File: rtl/byte_fifo_pwm_pkg.sv
package byte_fifo_pwm_pkg;

  // Strobes from the control module to the datapath, one cycle each.
  typedef struct packed {
    logic flush;        // empty the queue and clear the duty value
    logic pushFirst;    // write the first byte of this cycle
    logic pushSecond;   // write the low byte behind the first one
    logic firstFromHi;  // first byte comes from the upper lane
    logic pop;          // move the oldest sample into the duty register
  } pwm_strobe_t;

endpackage

// File: rtl/byte_fifo_pwm_ctrl.sv
module byte_fifo_pwm_ctrl
  import byte_fifo_pwm_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int PERIOD_W = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic                wrValid,
  input  logic                wrLaneHi,
  input  logic                wrLaneLo,
  input  logic [CNT_W-1:0]    fillLevel,
  output pwm_strobe_t         strobe,
  output logic [PERIOD_W-1:0] phase
);

  localparam logic [CNT_W-1:0] DEPTH_L = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TWO_L   = CNT_W'(2);

  logic [PERIOD_W-1:0] phaseQ;
  logic [CNT_W-1:0]    freeSlots;
  logic                wrapNow;
  logic                wordWrite;
  logic                byteWrite;

  // A period ends on the counter's limit; a limit lowered mid-period wraps at once.
  assign wrapNow = enable && (phaseQ >= period);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (!enable || wrapNow) begin
      phaseQ <= '0;
    end else begin
      phaseQ <= phaseQ + PERIOD_W'(1);
    end
  end

  assign phase     = phaseQ;
  assign freeSlots = DEPTH_L - fillLevel;
  assign wordWrite = enable && wrValid && wrLaneHi && wrLaneLo;
  assign byteWrite = enable && wrValid && !wrLaneHi && wrLaneLo;

  always_comb begin
    strobe             = '0;
    strobe.flush       = !enable;
    strobe.firstFromHi = wordWrite;
    strobe.pushFirst   = (wordWrite || byteWrite) && (freeSlots != '0);
    strobe.pushSecond  = wordWrite && (freeSlots >= TWO_L);
    strobe.pop         = wrapNow && (fillLevel != '0);
  end

endmodule

// File: rtl/byte_fifo_pwm_datapath.sv
module byte_fifo_pwm_datapath
  import byte_fifo_pwm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int PERIOD_W = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CMP_W   = (DATA_W > PERIOD_W) ? DATA_W + 1 : PERIOD_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pwm_strobe_t           strobe,
  input  logic [2*DATA_W-1:0]   wrData,
  input  logic [PERIOD_W-1:0]   phase,
  output logic [CNT_W-1:0]      fillLevel,
  output logic                  pwmOut,
  output logic                  fifoEmpty,
  output logic                  fifoFull
);

  localparam logic [CNT_W-1:0] DEPTH_L = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [DATA_W-1:0] slotQ [DEPTH];
  logic [PTR_W-1:0]  wrPtrQ;
  logic [PTR_W-1:0]  rdPtrQ;
  logic [PTR_W-1:0]  wrPtrPlus1;
  logic [CNT_W-1:0]  fillQ;
  logic [DATA_W-1:0] dutyQ;
  logic [DATA_W-1:0] firstByte;

  assign wrPtrPlus1 = nextPtr(wrPtrQ);
  assign firstByte  = strobe.firstFromHi ? wrData[2*DATA_W-1:DATA_W] : wrData[DATA_W-1:0];

  // Each slot has its own write enable; sample storage needs no reset.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.pushFirst && (wrPtrQ == PTR_W'(i))) begin
        slotQ[i] <= firstByte;
      end else if (strobe.pushSecond && (wrPtrPlus1 == PTR_W'(i))) begin
        slotQ[i] <= wrData[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      fillQ  <= '0;
      dutyQ  <= '0;
    end else begin
      if (strobe.pushSecond) begin
        wrPtrQ <= nextPtr(wrPtrPlus1);
      end else if (strobe.pushFirst) begin
        wrPtrQ <= wrPtrPlus1;
      end
      if (strobe.pop) begin
        rdPtrQ <= nextPtr(rdPtrQ);
        dutyQ  <= slotQ[rdPtrQ];
      end
      fillQ <= fillQ + CNT_W'(strobe.pushFirst) + CNT_W'(strobe.pushSecond)
                     - CNT_W'(strobe.pop);
    end
  end

  assign fillLevel = fillQ;
  assign fifoEmpty = (fillQ == '0);
  assign fifoFull  = (fillQ == DEPTH_L);
  assign pwmOut    = !strobe.flush && (CMP_W'(phase) < CMP_W'(dutyQ));

endmodule

// File: rtl/byte_fifo_pwm.sv
module byte_fifo_pwm
  import byte_fifo_pwm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int PERIOD_W = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic                wrValid,
  input  logic                wrLaneHi,
  input  logic                wrLaneLo,
  input  logic [2*DATA_W-1:0] wrData,
  output logic                pwmOut,
  output logic                fifoEmpty,
  output logic                fifoFull
);

  pwm_strobe_t         strobe;
  logic [PERIOD_W-1:0] phase;
  logic [CNT_W-1:0]    fillLevel;

  byte_fifo_pwm_ctrl #(
    .DEPTH(DEPTH), .PERIOD_W(PERIOD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .period(period),
    .wrValid(wrValid), .wrLaneHi(wrLaneHi), .wrLaneLo(wrLaneLo),
    .fillLevel(fillLevel), .strobe(strobe), .phase(phase)
  );

  byte_fifo_pwm_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PERIOD_W(PERIOD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .phase(phase),
    .fillLevel(fillLevel), .pwmOut(pwmOut),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

endmodule

// File: rtl/byte_fifo_pwm_checker.sv
module byte_fifo_pwm_checker #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic [PERIOD_W-1:0] period,
  input logic [PERIOD_W-1:0] phase,
  input logic                popStb,
  input logic                pwmOut,
  input logic                fifoEmpty,
  input logic                fifoFull
);

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && fifoFull && !popStb) |=> fifoFull);

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == period) |=> (phase == '0));

  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase < period) |=> (phase == '0 || phase == $past(phase) + PERIOD_W'(1)));

  a_r8_pop_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    popStb |-> !fifoEmpty);

  a_r9_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !pwmOut);

  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (fifoEmpty && phase == '0));

endmodule

bind byte_fifo_pwm byte_fifo_pwm_checker #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .period(period), .phase(phase),
  .popStb(strobe.pop), .pwmOut(pwmOut), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
);

// File: tb/byte_fifo_pwm_bench.sv
module byte_fifo_pwm_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, enable, wrValid, wrLaneHi, wrLaneLo;
  logic [7:0]  period;
  logic [15:0] wrData;
  logic        pwmOut, fifoEmpty, fifoFull;

  int  total = 0;
  int  bad = 0;
  int  sinceEn = 0;
  bit  done = 1'b0;

  byte_fifo_pwm u_byte_fifo_pwm (
    .clk(clk), .rstN(rstN), .enable(enable), .period(period),
    .wrValid(wrValid), .wrLaneHi(wrLaneHi), .wrLaneLo(wrLaneLo), .wrData(wrData),
    .pwmOut(pwmOut), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

  // {period, duty written on the low lane, expected high cycles}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'd5,  8'd0,   8'd0},
    {8'd5,  8'd3,   8'd3},
    {8'd5,  8'd5,   8'd5},
    {8'd5,  8'd6,   8'd6},
    {8'd5,  8'd200, 8'd6},
    {8'd15, 8'd1,   8'd1},
    {8'd2,  8'd255, 8'd3},
    {8'd9,  8'd9,   8'd9}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    sinceEn++;
  endtask

  task automatic startRun(input int p);
    enable = 1'b0;
    cyc();
    period  = 8'(p);
    enable  = 1'b1;
    sinceEn = 0;
  endtask

  task automatic wr(input logic hi, input logic lo, input logic [15:0] d);
    wrValid = 1'b1; wrLaneHi = hi; wrLaneLo = lo; wrData = d;
    cyc();
    wrValid = 1'b0; wrLaneHi = 1'b0; wrLaneLo = 1'b0; wrData = '0;
  endtask

  task automatic toBoundary(input int p);
    while (sinceEn % (p + 1) != 0) cyc();
  endtask

  task automatic measure(input int p, output int highs);
    highs = 0;
    for (int i = 0; i <= p; i++) begin
      if (pwmOut === 1'b1) highs++;
      cyc();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h;
    int seq [5];
    logic bits [8];
    rstN = 1'b0; enable = 1'b0; period = 8'd0;
    wrValid = 1'b0; wrLaneHi = 1'b0; wrLaneLo = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    check("R3 reset empty", int'(fifoEmpty), 1);
    check("R3 reset full", int'(fifoFull), 0);
    check("R9 reset pin", int'(pwmOut), 0);
    rstN = 1'b1;

    // Table: single low-lane sample, measured in the period after the lead-in.
    for (int v = 0; v < NV; v++) begin
      int p, e;
      p = int'(VEC[v][23:16]);
      e = int'(VEC[v][7:0]);
      startRun(p);
      wr(1'b0, 1'b1, {8'h00, VEC[v][15:8]});
      toBoundary(p);
      measure(p, h);
      check($sformatf("R6/R7 vec%0d duty", v), h, e);
    end

    // R1: word write plays upper byte first, then lower; R8 replay afterwards.
    startRun(9);
    wr(1'b1, 1'b1, 16'h0305);
    toBoundary(9);
    for (int k = 0; k < 3; k++) begin measure(9, h); seq[k] = h; end
    check("R1 first sample", seq[0], 3);
    check("R1 second sample", seq[1], 5);
    check("R8 replay on empty", seq[2], 5);

    // R2: high lane alone is ignored; low lane alone enqueues bits 7:0.
    startRun(7);
    wr(1'b1, 1'b0, 16'hAA00);
    check("R2 high-only ignored", int'(fifoEmpty), 1);
    wr(1'b0, 1'b1, 16'h1206);
    check("R2 low-only enqueued", int'(fifoEmpty), 0);
    toBoundary(7);
    measure(7, h);
    check("R2 low byte played", h, 6);

    // R3: fill to four, extra write dropped.
    startRun(20);
    wr(1'b1, 1'b1, 16'h0102);
    wr(1'b1, 1'b1, 16'h0300);
    check("R3 full flag", int'(fifoFull), 1);
    wr(1'b0, 1'b1, 16'h0009);
    check("R3 still full", int'(fifoFull), 1);
    toBoundary(20);
    for (int k = 0; k < 5; k++) begin measure(20, h); seq[k] = h; end
    check("R3 seq0", seq[0], 1);
    check("R3 seq1", seq[1], 2);
    check("R3 seq2", seq[2], 3);
    check("R3 seq3", seq[3], 0);
    check("R3 dropped write absent", seq[4], 0);
    check("R3 empty after drain", int'(fifoEmpty), 1);

    // R4: word write with one slot free, in the same cycle as a wrap pop.
    startRun(3);
    wr(1'b0, 1'b1, 16'h0001);
    wr(1'b0, 1'b1, 16'h0002);
    wr(1'b0, 1'b1, 16'h0003);
    wr(1'b1, 1'b1, 16'h0405);
    check("R4 not full after coincident pop", int'(fifoFull), 0);
    toBoundary(3);
    for (int k = 0; k < 5; k++) begin measure(3, h); seq[k] = h; end
    check("R4 seq0", seq[0], 1);
    check("R4 seq1", seq[1], 2);
    check("R4 seq2", seq[2], 3);
    check("R4 high byte kept", seq[3], 4);
    check("R4 low byte dropped", seq[4], 4);

    // R5: period length is period+1 cycles, seen as pin edges.
    startRun(6);
    wr(1'b0, 1'b1, 16'h0002);
    toBoundary(6);
    for (int i = 0; i < 8; i++) begin bits[i] = pwmOut; cyc(); end
    check("R5 high at start", int'(bits[0]), 1);
    check("R5 low at duty", int'(bits[2]), 0);
    check("R5 low at limit", int'(bits[6]), 0);
    check("R5 high after wrap", int'(bits[7]), 1);

    // R9: disable flushes and silences; writes while off are ignored.
    wr(1'b1, 1'b1, 16'h0404);
    check("R9 queue loaded", int'(fifoEmpty), 0);
    enable = 1'b0;
    #1;
    check("R9 pin low when off", int'(pwmOut), 0);
    cyc();
    check("R9 flushed", int'(fifoEmpty), 1);
    wr(1'b0, 1'b1, 16'h0007);
    check("R9 write while off ignored", int'(fifoEmpty), 1);
    enable = 1'b1; sinceEn = 0;
    measure(6, h);
    check("R9 lead-in silent", h, 0);
    measure(6, h);
    check("R9 duty cleared", h, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule